// File: doc/BRIEF.md
# Programmable Pulse Generator Timer

This block is a 16-bit timer that turns register settings into a repeating pulse waveform. An up counter advances on a strobe picked from three prescaler taps. Two compare values are checked against it: a period value, at which the counter wraps back to zero, and a duty value, at which the output changes level partway through each period. The output comes from a flip-flop that inverts on compare events. It does not compare levels. With both toggle sources enabled, the output is low for the first part of each period and high for the rest, or the reverse if the flip-flop starts high.

The duty compare value can be written in two ways. With buffering off, a write takes effect on the next clock. With buffering on, a write lands in a shadow register and is copied into the active compare value only at the period wrap. This lets software retune a running waveform without producing a glitch. Each period wrap also raises a one-cycle interrupt strobe. Everything runs in a single clock domain, and the prescaler issues enable strobes rather than derived clocks.

Top module: `ppg_timer`

## Requirements
- R1: While running, the counter rises by one on each selected tick. On a tick where it equals the period value, it goes to 0 instead of rising.
- R2: While running, a base tick occurs once every BASE_DIV clocks. `clk_sel` picks the counter tick: 0 gives every base tick, 1 gives every 4th, 2 gives every 16th, and 3 gives no ticks, so the counter holds.
- R3: When `run_en` is low, the counter and the prescaler are cleared to 0 on the next clock, and `pulse_out` keeps its level.
- R4: With `tog_on_duty` high, `pulse_out` inverts on a tick where the counter equals the active duty value and that duty value is below the period value.
- R5: With `tog_on_period` high, `pulse_out` inverts on a tick where the counter equals the period value. If a toggle enable is low, its match has no effect on `pulse_out`.
- R6: When the active duty value is greater than or equal to the period value, no duty toggle ever happens, and only period matches change `pulse_out`.
- R7: With `dbuf_en` low, a duty write becomes the active compare value on the next clock.
- R8: With `dbuf_en` high, a duty write goes only to the shadow register. The active value loads the shadow value on a period match. If a write and a period match fall on the same clock, the active value takes the shadow value from before that write.
- R9: `out_clear` forces `pulse_out` to 0 on the next clock and takes priority over any toggle on that clock.
- R10: `period_irq` is high for exactly the one cycle after each period-match tick, which is the cycle in which the counter reads 0.
- R11: After reset, the counter, `pulse_out` and `period_irq` are 0, the active and shadow duty values are 0, and the period value is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Counter runs while high; low clears it |
| clk_sel | input | 2 | Tick select: 0 /1, 1 /4, 2 /16, 3 hold |
| dbuf_en | input | 1 | Duty double-buffer enable |
| duty_we | input | 1 | Duty write strobe |
| duty_wdata | input | 16 | Duty write value |
| period_we | input | 1 | Period write strobe |
| period_wdata | input | 16 | Period write value |
| tog_on_duty | input | 1 | Duty match toggles the output |
| tog_on_period | input | 1 | Period match toggles the output |
| out_clear | input | 1 | Forces the output flip-flop to 0 |
| pulse_out | output | 1 | Pulse waveform output |
| period_irq | output | 1 | One-cycle period-match strobe |
| count_val | output | 16 | Present counter value |

## Verification
Several properties are checked on every clock:
- the interrupt coincides with a zero count;
- a stopped counter reads zero;
- the hold tap freezes the counter;
- the counter never moves by anything other than +1 or a wrap to zero;
- a clear drives the output low;
- the output changes only while running or when cleared;
- with buffering on, the active duty value changes only together with the interrupt.

Other behaviours need the bench's reference model and its scenarios:
- the exact tick spacing of each prescaler tap;
- the cycle on which a duty toggle lands;
- suppression of the duty toggle when duty is at or above period;
- the same-clock collision between a shadow write and a reload.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

   typedef enum logic [1:0] {
      SEL_T1   = 2'd0,
      SEL_T4   = 2'd1,
      SEL_T16  = 2'd2,
      SEL_HOLD = 2'd3
   } ppg_sel_e;

   typedef struct packed {
      logic duty_hit;
      logic period_hit;
   } ppg_match_t;

endpackage

// File: rtl/ppg_prescaler.sv
module ppg_prescaler
   import ppg_pkg::*;
#(
   parameter int BASE_DIV  = 2,
   parameter int TAP_A_LOG = 2,
   parameter int TAP_B_LOG = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [1:0] sel,
   output logic       cnt_tick
);
   localparam int DIV_W = TAP_B_LOG;

   if (BASE_DIV < 1) begin : g_bad_div
      $error("BASE_DIV must be at least 1");
   end
   if (TAP_A_LOG < 1 || TAP_A_LOG >= TAP_B_LOG) begin : g_bad_tap
      $error("tap widths must satisfy 1 <= TAP_A_LOG < TAP_B_LOG");
   end

   logic             base_tick;
   logic [DIV_W-1:0] div_q;
   ppg_sel_e         sel_e;

   assign sel_e = ppg_sel_e'(sel);

   if (BASE_DIV == 1) begin : g_base_direct
      assign base_tick = run;
   end else begin : g_base_count
      localparam int BASE_W = $clog2(BASE_DIV);
      localparam logic [BASE_W-1:0] BASE_LAST = BASE_W'(BASE_DIV - 1);
      logic [BASE_W-1:0] base_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q <= '0;
         end else if (!run) begin
            base_q <= '0;
         end else if (base_q == BASE_LAST) begin
            base_q <= '0;
         end else begin
            base_q <= base_q + 1'b1;
         end
      end

      assign base_tick = run && (base_q == BASE_LAST);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
      end else if (!run) begin
         div_q <= '0;
      end else if (base_tick) begin
         div_q <= div_q + 1'b1;
      end
   end

   always_comb begin
      unique case (sel_e)
         SEL_T1:   cnt_tick = base_tick;
         SEL_T4:   cnt_tick = base_tick && (&div_q[TAP_A_LOG-1:0]);
         SEL_T16:  cnt_tick = base_tick && (&div_q);
         default:  cnt_tick = 1'b0;
      endcase
   end

endmodule

// File: rtl/ppg_duty_reg.sv
module ppg_duty_reg #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dbuf_en,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   input  logic             reload,
   output logic [CNT_W-1:0] duty_act
);
   logic [CNT_W-1:0] shadow_q;
   logic [CNT_W-1:0] active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
      end else if (wr) begin
         shadow_q <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= '0;
      end else if (dbuf_en) begin
         if (reload) begin
            active_q <= shadow_q;
         end
      end else if (wr) begin
         active_q <= wdata;
      end
   end

   assign duty_act = active_q;

endmodule

// File: rtl/ppg_core.sv
module ppg_core
   import ppg_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] duty_act,
   input  logic [CNT_W-1:0] period,
   input  logic             en_duty,
   input  logic             en_period,
   input  logic             ff_clear,
   output logic [CNT_W-1:0] cnt,
   output logic             pulse,
   output logic             irq,
   output logic             reload
);
   logic [CNT_W-1:0] cnt_q;
   logic             ff_q;
   logic             irq_q;
   ppg_match_t       hit;
   logic             flip;

   always_comb begin
      hit.period_hit = tick && (cnt_q == period);
      hit.duty_hit   = tick && (cnt_q == duty_act) && (duty_act < period);
      flip           = (hit.duty_hit && en_duty) ^ (hit.period_hit && en_period);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || hit.period_hit) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ff_q  <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         irq_q <= hit.period_hit;
         if (ff_clear) begin
            ff_q <= 1'b0;
         end else if (flip) begin
            ff_q <= ~ff_q;
         end
      end
   end

   assign cnt    = cnt_q;
   assign pulse  = ff_q;
   assign irq    = irq_q;
   assign reload = hit.period_hit;

endmodule

// File: rtl/ppg_timer.sv
module ppg_timer
   import ppg_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int BASE_DIV  = 2,
   parameter int TAP_A_LOG = 2,
   parameter int TAP_B_LOG = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic [1:0]       clk_sel,
   input  logic             dbuf_en,
   input  logic             duty_we,
   input  logic [CNT_W-1:0] duty_wdata,
   input  logic             period_we,
   input  logic [CNT_W-1:0] period_wdata,
   input  logic             tog_on_duty,
   input  logic             tog_on_period,
   input  logic             out_clear,
   output logic             pulse_out,
   output logic             period_irq,
   output logic [CNT_W-1:0] count_val
);
   if (CNT_W < 2) begin : g_bad_width
      $error("CNT_W must be at least 2");
   end

   logic             tick;
   logic             reload;
   logic [CNT_W-1:0] duty_act;
   logic [CNT_W-1:0] period_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_q <= '1;
      end else if (period_we) begin
         period_q <= period_wdata;
      end
   end

   ppg_prescaler #(
      .BASE_DIV (BASE_DIV),
      .TAP_A_LOG(TAP_A_LOG),
      .TAP_B_LOG(TAP_B_LOG)
   ) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_en),
      .sel     (clk_sel),
      .cnt_tick(tick)
   );

   ppg_duty_reg #(.CNT_W(CNT_W)) u_duty (
      .clk     (clk),
      .rst_n   (rst_n),
      .dbuf_en (dbuf_en),
      .wr      (duty_we),
      .wdata   (duty_wdata),
      .reload  (reload),
      .duty_act(duty_act)
   );

   ppg_core #(.CNT_W(CNT_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_en),
      .tick     (tick),
      .duty_act (duty_act),
      .period   (period_q),
      .en_duty  (tog_on_duty),
      .en_period(tog_on_period),
      .ff_clear (out_clear),
      .cnt      (count_val),
      .pulse    (pulse_out),
      .irq      (period_irq),
      .reload   (reload)
   );

endmodule

// File: rtl/ppg_timer_chk.sv
module ppg_timer_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run_en,
   input logic [1:0]       clk_sel,
   input logic             dbuf_en,
   input logic             out_clear,
   input logic             pulse_out,
   input logic             period_irq,
   input logic [CNT_W-1:0] count_val,
   input logic [CNT_W-1:0] duty_act
);
   logic past_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   // R10
   irq_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      period_irq |-> (count_val == '0));

   // R3
   stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> (count_val == '0));

   // R2
   hold_tap_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      ($past(clk_sel) == 2'd3 && $past(run_en)) |-> $stable(count_val));

   // R1
   step_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      (count_val == $past(count_val)) || (count_val == $past(count_val) + 1'b1)
      || (count_val == '0));

   // R9
   clear_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_clear |=> !pulse_out);

   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      ($past(!run_en) && $past(!out_clear)) |-> $stable(pulse_out));

   // R8
   buffered_reload_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      ($past(dbuf_en) && !$stable(duty_act)) |-> period_irq);

endmodule

bind ppg_timer ppg_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .run_en    (run_en),
   .clk_sel   (clk_sel),
   .dbuf_en   (dbuf_en),
   .out_clear (out_clear),
   .pulse_out (pulse_out),
   .period_irq(period_irq),
   .count_val (count_val),
   .duty_act  (duty_act)
);

// File: tb/ppg_timer_bench.sv
module ppg_timer_bench;
   localparam int W  = 16;
   localparam int BD = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         run_en = 1'b0;
   logic [1:0]   clk_sel = 2'd0;
   logic         dbuf_en = 1'b0;
   logic         duty_we = 1'b0;
   logic [W-1:0] duty_wdata = '0;
   logic         period_we = 1'b0;
   logic [W-1:0] period_wdata = '0;
   logic         tog_on_duty = 1'b1;
   logic         tog_on_period = 1'b1;
   logic         out_clear = 1'b0;
   logic         pulse_out;
   logic         period_irq;
   logic [W-1:0] count_val;

   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;
   string tag = "R11";

   // behavioural reference state
   int m_cnt = 0, m_ff = 0, m_irq = 0, m_base = 0, m_div = 0;
   int m_duty = 0, m_buf = 0, m_per = 65535;

   always #5 clk = ~clk;

   ppg_timer #(.CNT_W(W), .BASE_DIV(BD)) u_ppg_timer (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .clk_sel(clk_sel),
      .dbuf_en(dbuf_en), .duty_we(duty_we), .duty_wdata(duty_wdata),
      .period_we(period_we), .period_wdata(period_wdata),
      .tog_on_duty(tog_on_duty), .tog_on_period(tog_on_period),
      .out_clear(out_clear), .pulse_out(pulse_out),
      .period_irq(period_irq), .count_val(count_val)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      int  bt, tk, phit, dhit, nduty;
      if (!rst_n) begin
         m_cnt = 0; m_ff = 0; m_irq = 0; m_base = 0; m_div = 0;
         m_duty = 0; m_buf = 0; m_per = 65535;
      end else begin
         bt = (run_en && m_base == BD - 1) ? 1 : 0;
         case (clk_sel)
            2'd0:    tk = bt;
            2'd1:    tk = (bt && (m_div % 4) == 3) ? 1 : 0;
            2'd2:    tk = (bt && m_div == 15) ? 1 : 0;
            default: tk = 0;
         endcase
         phit = (tk && m_cnt == m_per) ? 1 : 0;
         dhit = (tk && m_cnt == m_duty && m_duty < m_per) ? 1 : 0;
         if (out_clear) m_ff = 0;
         else m_ff = m_ff ^ (dhit & int'(tog_on_duty)) ^ (phit & int'(tog_on_period));
         if (!run_en || phit == 1) m_cnt = 0;
         else if (tk == 1) m_cnt = (m_cnt + 1) % 65536;
         if (!run_en) begin
            m_base = 0; m_div = 0;
         end else begin
            m_base = (bt == 1) ? 0 : m_base + 1;
            if (bt == 1) m_div = (m_div + 1) % 16;
         end
         m_irq = phit;
         nduty = m_duty;
         if (dbuf_en) begin
            if (phit == 1) nduty = m_buf;
         end else if (duty_we) begin
            nduty = int'(duty_wdata);
         end
         if (duty_we) m_buf = int'(duty_wdata);
         m_duty = nduty;
         if (period_we) m_per = int'(period_wdata);
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(int'(count_val) == m_cnt, {tag, " count R1"}, int'(count_val), m_cnt);
         chk(int'(pulse_out) == m_ff, {tag, " output R4"}, int'(pulse_out), m_ff);
         chk(int'(period_irq) == m_irq, {tag, " irq R10"}, int'(period_irq), m_irq);
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_duty(input int v);
      duty_we = 1'b1; duty_wdata = W'(v); cyc(1); duty_we = 1'b0;
   endtask

   task automatic wr_period(input int v);
      period_we = 1'b1; period_wdata = W'(v); cyc(1); period_we = 1'b0;
   endtask

   task automatic clear_out();
      out_clear = 1'b1; cyc(1); out_clear = 1'b0;
   endtask

   initial begin
      cyc(2);
      chk(count_val == '0, "R11 count", int'(count_val), 0);
      chk(pulse_out == 1'b0, "R11 output", int'(pulse_out), 0);
      chk(period_irq == 1'b0, "R11 irq", int'(period_irq), 0);
      rst_n = 1'b1;
      cyc(2);

      tag = "R1";
      wr_period(7); wr_duty(3); clear_out();
      run_en = 1'b1; cyc(60);

      tag = "R2";
      clk_sel = 2'd1; cyc(130);
      clk_sel = 2'd2; wr_period(3); cyc(300);
      clk_sel = 2'd3; cyc(40);

      tag = "R3";
      clk_sel = 2'd0; cyc(7);
      run_en = 1'b0; cyc(2);
      chk(count_val == '0, "R3 stopped count", int'(count_val), 0);
      cyc(5); run_en = 1'b1; wr_period(9); cyc(50);

      tag = "R5";
      tog_on_duty = 1'b0; cyc(60);
      tag = "R4";
      tog_on_duty = 1'b1; tog_on_period = 1'b0; cyc(60);
      tog_on_period = 1'b1;

      tag = "R6";
      wr_duty(12); cyc(60);
      wr_duty(9); cyc(60);

      tag = "R7";
      wr_duty(2); cyc(13); wr_duty(6); cyc(40);

      tag = "R8";
      dbuf_en = 1'b1; cyc(3);
      wr_duty(4); cyc(45);
      for (int k = 0; k < 25; k++) begin
         wr_duty(1 + (k % 7));
      end
      cyc(40);
      dbuf_en = 1'b0;

      tag = "R9";
      cyc(5);
      clear_out();
      chk(pulse_out == 1'b0, "R9 cleared output", int'(pulse_out), 0);
      cyc(50);

      tag = "R10";
      wr_period(0); cyc(30);
      wr_period(2); cyc(40);
      run_en = 1'b0; cyc(3);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule